// File: doc/BRIEF.md
# Doorbell-Driven Transfer Ring Consumer

This block is the device-side engine for a single channel's transfer ring. The ring is a circular queue of fixed-size elements held in host memory. Host software sets the ring's base address, its length in elements, and the read and write indices through a small register port. After it queues work, it pulses a doorbell. The block then reads elements from memory, starting at the read index and stopping at the write index. It issues one read request per element over a request/response port. Each returned element goes to a downstream consumer over a valid/ready handshake, and the read index advances by one for each element the consumer accepts.

Each element is 64 bits: bits 31:0 hold a buffer pointer, bits 47:32 hold a buffer size, and bits 63:48 hold control flags. Bit 48 is the chain flag. When it is set, the following element belongs to the same descriptor. The block raises a one-cycle completion pulse for each descriptor, on its final element only. A doorbell that arrives while a fetch is running is remembered. The write index is sampled again once the current descriptor has ended. Nothing is fetched until the channel enable input is high, which models the channel-start command.

Top module: `xrc_ring_consumer`

## Requirements
- R1: After reset, `mrd_req_valid`, `elem_valid` and `desc_done` are low and `ring_rp` is 0.
- R2: Changing the write index without a doorbell causes no memory read request.
- R3: After a doorbell, read requests are issued one at a time for indices from the read index up to, but not including, the write index. Each request address is base + index*ELEM_BYTES (16 by default). A doorbell on an empty ring (read index equal to write index) causes no request.
- R4: `elem_data` carries the returned element unchanged, and once `elem_valid` is high, it and `elem_data` hold steady until `elem_ready` is seen high.
- R5: `ring_rp` advances by exactly one for each accepted element and returns to 0 after index length-1.
- R6: `desc_done` pulses for one cycle, in the cycle after an element with bit 48 clear is accepted. An accepted element with bit 48 set gives no pulse.
- R7: A doorbell received during a fetch is held, and once the current descriptor ends, work queued up to the new write index is also fetched.
- R8: No new read request starts while `chan_en` is low. A doorbell received while it is low is kept and served once it rises.
- R9: Register writes use select codes 0 = base, 1 = length, 2 = read index, 3 = write index. Writes to base, length and read index take effect only while `chan_en` is low. Writes to the write index always take effect.
- R10: When the write index is one behind the read index (a full ring), length-1 elements are fetched and `ring_rp` ends equal to the write index.
- R11: Once `mrd_req_valid` is high, it and `mrd_req_addr` hold steady until `mrd_req_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel started; gates all fetching |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 base, 1 length, 2 read index, 3 write index) |
| cfg_wdata | input | AW | Register write data |
| doorbell | input | 1 | One-cycle pulse: new work queued |
| ring_rp | output | IDX_W | Current read index |
| mrd_req_valid | output | 1 | Memory read request valid |
| mrd_req_ready | input | 1 | Memory read request accepted |
| mrd_req_addr | output | AW | Byte address of the element to read |
| mrd_rsp_valid | input | 1 | Read data valid |
| mrd_rsp_data | input | ELEM_W | Returned element |
| elem_valid | output | 1 | Element offered downstream |
| elem_ready | input | 1 | Downstream accepts element |
| elem_data | output | ELEM_W | Element passed downstream |
| desc_done | output | 1 | One-cycle completion pulse per descriptor |

## Verification
The main function is tried with several descriptor patterns. A single-element descriptor checks the basic index step and the completion pulse. A three-element chain followed by a single element checks that exactly one pulse fires per descriptor. A chain that crosses the ring end shows whether the wrap uses the programmed length. A completely full ring checks the case where one slot stays unused. Doorbells are applied in varied orders: withheld, rung on an empty ring, rung in the middle of a fetch, and rung while the channel is disabled. These separate correct doorbell latching from fetching on a write-index change alone and from dropping late doorbells. Readiness on both handshakes is throttled in a repeating pattern, so held requests and held elements are checked on every clock against a behavioural queue model.

// File: rtl/xrc_pkg.sv
package xrc_pkg;

  // Element layout: [31:0] buffer pointer, [47:32] size, [63:48] control
  localparam int XRC_ELEM_W    = 64;
  localparam int XRC_CHAIN_BIT = 48;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_RP   = 2'd2,
    SEL_WP   = 2'd3
  } xrc_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_PUSH
  } xrc_state_e;

endpackage

// File: rtl/xrc_ctx_regs.sv
module xrc_ctx_regs
  import xrc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             adv,
  output logic [AW-1:0]    base_q,
  output logic [IDX_W-1:0] len_q,
  output logic [IDX_W-1:0] rp_q,
  output logic [IDX_W-1:0] wp_q,
  output logic [IDX_W-1:0] rp_nxt
);

  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_ZERO = '0;

  // Index after idx on a ring of len elements; wraps to slot 0
  function automatic logic [IDX_W-1:0] ring_step(input logic [IDX_W-1:0] idx,
                                                 input logic [IDX_W-1:0] len);
    logic [IDX_W-1:0] inc;
    inc = idx + IDX_ONE;
    return (inc >= len) ? IDX_ZERO : inc;
  endfunction

  xrc_sel_e sel;
  logic     ctx_open;

  assign sel      = xrc_sel_e'(cfg_sel);
  assign ctx_open = cfg_we && !chan_en;
  assign rp_nxt   = ring_step(rp_q, len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '1;
      rp_q   <= '0;
      wp_q   <= '0;
    end else begin
      if (cfg_we && sel == SEL_WP)    wp_q   <= cfg_wdata[IDX_W-1:0];
      if (ctx_open && sel == SEL_BASE) base_q <= cfg_wdata;
      if (ctx_open && sel == SEL_LEN)  len_q  <= cfg_wdata[IDX_W-1:0];
      if (ctx_open && sel == SEL_RP)   rp_q   <= cfg_wdata[IDX_W-1:0];
      else if (adv)                    rp_q   <= rp_nxt;
    end
  end

endmodule

// File: rtl/xrc_fetch_ctrl.sv
module xrc_fetch_ctrl
  import xrc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int IDX_W      = 8,
  parameter int ELEM_BYTES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chan_en,
  input  logic                  doorbell,
  input  logic [AW-1:0]         base_q,
  input  logic [IDX_W-1:0]      rp_q,
  input  logic [IDX_W-1:0]      wp_q,
  input  logic [IDX_W-1:0]      rp_nxt,
  output logic                  mrd_req_valid,
  input  logic                  mrd_req_ready,
  output logic [AW-1:0]         mrd_req_addr,
  input  logic                  mrd_rsp_valid,
  input  logic [XRC_ELEM_W-1:0] mrd_rsp_data,
  output logic                  elem_valid,
  input  logic                  elem_ready,
  output logic [XRC_ELEM_W-1:0] elem_data,
  output logic                  adv,
  output logic                  desc_done
);

  localparam int STRIDE_LG = $clog2(ELEM_BYTES);

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0]    base,
                                               input logic [IDX_W-1:0] idx);
    return base + (AW'(idx) << STRIDE_LG);
  endfunction

  xrc_state_e              state_q;
  logic                    db_pend_q;
  logic [IDX_W-1:0]        snap_q;
  logic [XRC_ELEM_W-1:0]   elem_q;
  logic                    done_q;

  // Named internal events
  logic             start_go;
  logic             push_fire;
  logic             elem_last;
  logic             resample;
  logic             take_db;
  logic             keep_going;
  logic [IDX_W-1:0] snap_eff;

  assign start_go   = (state_q == ST_IDLE) && chan_en && db_pend_q;
  assign push_fire  = (state_q == ST_PUSH) && elem_ready;
  assign elem_last  = !elem_q[XRC_CHAIN_BIT];
  assign resample   = push_fire && elem_last && db_pend_q;
  assign take_db    = start_go || resample;
  assign snap_eff   = resample ? wp_q : snap_q;
  assign keep_going = chan_en && (rp_nxt != snap_eff);

  assign mrd_req_valid = (state_q == ST_REQ);
  assign mrd_req_addr  = slot_addr(base_q, rp_q);
  assign elem_valid    = (state_q == ST_PUSH);
  assign elem_data     = elem_q;
  assign adv           = push_fire;
  assign desc_done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      db_pend_q <= 1'b0;
      snap_q    <= '0;
      elem_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q    <= push_fire && elem_last;
      db_pend_q <= take_db ? doorbell : (db_pend_q | doorbell);
      if (take_db) snap_q <= wp_q;
      unique case (state_q)
        ST_IDLE: if (start_go && rp_q != wp_q) state_q <= ST_REQ;
        ST_REQ:  if (mrd_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mrd_rsp_valid) begin
                   elem_q  <= mrd_rsp_data;
                   state_q <= ST_PUSH;
                 end
        ST_PUSH: if (elem_ready) state_q <= keep_going ? ST_REQ : ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_req_valid && !mrd_req_ready) |=> (mrd_req_valid && $stable(mrd_req_addr))); // R11

  AST_ELEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && !elem_ready) |=> (elem_valid && $stable(elem_data))); // R4

  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> $past(elem_valid && elem_ready && !elem_data[XRC_CHAIN_BIT])); // R6

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mrd_req_valid) |-> $past(chan_en)); // R8

endmodule

// File: rtl/xrc_ring_consumer.sv
module xrc_ring_consumer
  import xrc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int IDX_W      = 8,
  parameter int ELEM_BYTES = 16,
  parameter int ELEM_W     = XRC_ELEM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              doorbell,
  output logic [IDX_W-1:0]  ring_rp,
  output logic              mrd_req_valid,
  input  logic              mrd_req_ready,
  output logic [AW-1:0]     mrd_req_addr,
  input  logic              mrd_rsp_valid,
  input  logic [ELEM_W-1:0] mrd_rsp_data,
  output logic              elem_valid,
  input  logic              elem_ready,
  output logic [ELEM_W-1:0] elem_data,
  output logic              desc_done
);

  logic [AW-1:0]    base_q;
  logic [IDX_W-1:0] len_q;
  logic [IDX_W-1:0] rp_q;
  logic [IDX_W-1:0] wp_q;
  logic [IDX_W-1:0] rp_nxt;
  logic             adv;

  xrc_ctx_regs #(.AW(AW), .IDX_W(IDX_W)) u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .adv       (adv),
    .base_q    (base_q),
    .len_q     (len_q),
    .rp_q      (rp_q),
    .wp_q      (wp_q),
    .rp_nxt    (rp_nxt)
  );

  xrc_fetch_ctrl #(.AW(AW), .IDX_W(IDX_W), .ELEM_BYTES(ELEM_BYTES)) u_fetch (
    .clk           (clk),
    .rst_n         (rst_n),
    .chan_en       (chan_en),
    .doorbell      (doorbell),
    .base_q        (base_q),
    .rp_q          (rp_q),
    .wp_q          (wp_q),
    .rp_nxt        (rp_nxt),
    .mrd_req_valid (mrd_req_valid),
    .mrd_req_ready (mrd_req_ready),
    .mrd_req_addr  (mrd_req_addr),
    .mrd_rsp_valid (mrd_rsp_valid),
    .mrd_rsp_data  (mrd_rsp_data),
    .elem_valid    (elem_valid),
    .elem_ready    (elem_ready),
    .elem_data     (elem_data),
    .adv           (adv),
    .desc_done     (desc_done)
  );

  assign ring_rp = rp_q;

  AST_RP_ONLY_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chan_en) && ring_rp != $past(ring_rp)) |-> $past(elem_valid && elem_ready)); // R9

endmodule

// File: tb/xrc_ring_consumer_tb.sv
`timescale 1ns/1ps
module xrc_ring_consumer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        doorbell = 1'b0;
  logic [7:0]  ring_rp;
  logic        mrd_req_valid;
  logic        mrd_req_ready = 1'b0;
  logic [31:0] mrd_req_addr;
  logic        mrd_rsp_valid = 1'b0;
  logic [63:0] mrd_rsp_data = '0;
  logic        elem_valid;
  logic        elem_ready = 1'b0;
  logic [63:0] elem_data;
  logic        desc_done;

  always #2.5 clk = ~clk;

  xrc_ring_consumer u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .doorbell(doorbell),
    .ring_rp(ring_rp), .mrd_req_valid(mrd_req_valid), .mrd_req_ready(mrd_req_ready),
    .mrd_req_addr(mrd_req_addr), .mrd_rsp_valid(mrd_rsp_valid),
    .mrd_rsp_data(mrd_rsp_data), .elem_valid(elem_valid), .elem_ready(elem_ready),
    .elem_data(elem_data), .desc_done(desc_done)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit mon_on = 0;

  // Behavioural model state
  logic [63:0] mem [16];
  int m_base = 0;
  int m_len = 255;
  int m_rp = 0;
  bit m_done_exp = 0;
  int n_req = 0, n_elem = 0, n_done = 0;
  int cyc = 0;
  bit hs_pend = 0;
  int hs_slot = 0;
  bit req_wait = 0, elem_wait = 0;
  logic [31:0] req_addr_prev;
  logic [63:0] elem_prev;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int tag, input bit chain);
    return {15'd0, chain, 16'(tag * 4), 32'h8000_0000 + 32'(tag)};
  endfunction

  // Memory responder, reference model and per-clock comparison
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      cyc++;
      mrd_rsp_valid = hs_pend;
      if (hs_pend) mrd_rsp_data = mem[hs_slot];
      hs_pend = 0;

      chk(32'(ring_rp) == 32'(m_rp), "R5 ring_rp", ring_rp, m_rp);
      chk(desc_done == m_done_exp, "R6 desc_done", desc_done, m_done_exp);
      if (mrd_req_valid)
        chk(mrd_req_addr == 32'(m_base + m_rp * 16), "R3 req addr", mrd_req_addr, m_base + m_rp * 16);
      if (req_wait)
        chk(mrd_req_valid && mrd_req_addr == req_addr_prev, "R11 req held", mrd_req_addr, req_addr_prev);
      if (elem_wait)
        chk(elem_valid && elem_data == elem_prev, "R4 elem held", elem_data, elem_prev);

      mrd_req_ready = (cyc % 4) != 0;
      elem_ready    = (cyc % 3) != 1;

      req_wait = mrd_req_valid && !mrd_req_ready;
      req_addr_prev = mrd_req_addr;
      elem_wait = elem_valid && !elem_ready;
      elem_prev = elem_data;

      if (mrd_req_valid && mrd_req_ready) begin
        hs_pend = 1;
        hs_slot = int'((mrd_req_addr - 32'(m_base)) >> 4) % 16;
        n_req++;
      end
      if (elem_valid && elem_ready) begin
        chk(elem_data == mem[m_rp % 16], "R4 elem data", elem_data, mem[m_rp % 16]);
        m_done_exp = !elem_data[48];
        if (!elem_data[48]) n_done++;
        n_elem++;
        m_rp = (m_rp + 1 >= m_len) ? 0 : m_rp + 1;
      end else begin
        m_done_exp = 0;
      end
    end
  end

  task automatic cfg(input int sel, input int val);
    @(negedge clk); #1;
    cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = 32'(val);
    @(posedge clk); #1;
    cfg_we = 0;
    if (!chan_en) begin
      if (sel == 0) m_base = val;
      if (sel == 1) m_len = val;
      if (sel == 2) m_rp = val;
    end
  endtask

  task automatic ring();
    @(negedge clk); #1; doorbell = 1;
    @(posedge clk); #1; doorbell = 0;
  endtask

  task automatic set_en(input bit v);
    @(negedge clk); #1; chan_en = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int r0, e0, d0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk(!mrd_req_valid, "R1 req_valid", mrd_req_valid, 0);
    chk(!elem_valid, "R1 elem_valid", elem_valid, 0);
    chk(!desc_done, "R1 desc_done", desc_done, 0);
    chk(ring_rp == 0, "R1 ring_rp", ring_rp, 0);
    rst_n = 1;
    mon_on = 1;

    cfg(0, 32'h1000); cfg(1, 8); cfg(2, 0); cfg(3, 0);
    mem[0] = mk(1, 0);
    cfg(3, 1);
    set_en(1);
    idle(20);
    chk(n_req == 0, "R2 no fetch without doorbell", n_req, 0);
    chk(ring_rp == 0, "R2 ring_rp", ring_rp, 0);

    ring(); idle(40);
    chk(ring_rp == 1, "R3 single element rp", ring_rp, 1);
    chk(n_elem == 1 && n_done == 1, "R6 single done", n_done, 1);

    r0 = n_req;
    ring(); idle(20);
    chk(n_req == r0, "R3 empty doorbell", n_req, r0);

    // R7: second doorbell lands mid-fetch
    e0 = n_elem; d0 = n_done;
    mem[1] = mk(2, 1); mem[2] = mk(3, 1); mem[3] = mk(4, 0);
    cfg(3, 4); ring();
    idle(3);
    mem[4] = mk(5, 0);
    cfg(3, 5); ring();
    idle(120);
    chk(ring_rp == 5, "R7 latched doorbell rp", ring_rp, 5);
    chk(n_elem - e0 == 4, "R7 elements", n_elem - e0, 4);
    chk(n_done - d0 == 2, "R6 one done per descriptor", n_done - d0, 2);

    // R9: context writes ignored while enabled
    cfg(2, 6); cfg(0, 32'h2000); cfg(1, 3);
    idle(2);
    chk(ring_rp == 5, "R9 rp write ignored", ring_rp, 5);
    e0 = n_elem; d0 = n_done;
    mem[5] = mk(6, 1); mem[6] = mk(7, 1); mem[7] = mk(8, 1); mem[0] = mk(9, 0);
    cfg(3, 1); ring();
    idle(120);
    chk(ring_rp == 1, "R5 wrap at length", ring_rp, 1);
    chk(n_elem - e0 == 4 && n_done - d0 == 1, "R9 length kept", n_elem - e0, 4);

    // R8: doorbell while disabled is kept
    set_en(0);
    r0 = n_req;
    mem[1] = mk(10, 0);
    cfg(3, 2); ring();
    idle(20);
    chk(n_req == r0, "R8 no fetch disabled", n_req, r0);
    chk(ring_rp == 1, "R8 rp held", ring_rp, 1);
    set_en(1);
    idle(40);
    chk(ring_rp == 2, "R8 served on enable", ring_rp, 2);

    // R10: full ring
    set_en(0);
    cfg(1, 4); cfg(0, 32'h3000); cfg(2, 1); cfg(3, 0);
    mem[1] = mk(11, 0); mem[2] = mk(12, 0); mem[3] = mk(13, 0);
    e0 = n_elem;
    set_en(1); ring();
    idle(120);
    chk(ring_rp == 0, "R10 full ring rp", ring_rp, 0);
    chk(n_elem - e0 == 3, "R10 full ring count", n_elem - e0, 3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule